// File: doc/BRIEF.md
# Snooping Four-State Cache Line Coherence Controller

This block keeps the coherence state of every line in one cache that sits on a shared snooping bus. Each line has one 2-bit state. Two kinds of event drive the line states. The first kind comes from the local processor: a read or a write to a line address. The second kind comes from snooping: another cache on the bus reads or writes (claims) the same address. For each accepted event the block looks up the addressed line, works out its next state and writes it back. One cycle later it reports the old state, the new state and any bus command the cache must issue. The possible bus commands are a fetch, a claim that invalidates other copies, or a flush of dirty data.

A line that holds the only up-to-date copy of its data must be flushed to memory before any other cache may use that data. When a snoop hits such a line, the block raises a data-supply flag and issues a flush in the same response. Only after that is the line downgraded to Shared or dropped to Invalid. When a snooped read finds any valid copy, the block also raises a shared-hit flag, which tells the requesting cache that the line is shared. On a local read miss, the bus's shared-response input selects the line's new state: Shared if another cache holds a copy, Exclusive if none does.

The bus carries only one action per cycle. If a snoop and a local request arrive in the same cycle, the snoop is served and the local request is dropped. The processor side must then present the request again.

Top module: `mesi_line_ctrl`

## Requirements
- R1: State encoding is Invalid=2'b00, Shared=2'b01, Exclusive=2'b10, Modified=2'b11. A synchronous active-high reset sets every line to Invalid and every output to 0.
- R2: A local read of an Invalid line issues bus command 2'b01 (fetch). The line's next state is Shared when `lcl_shared` is 1 and Exclusive when it is 0.
- R3: A local read of a Shared, Exclusive or Modified line issues no bus command (2'b00) and leaves the state unchanged.
- R4: A local write to an Exclusive or Modified line makes it Modified with no bus command (2'b00).
- R5: A local write to a Shared or Invalid line makes it Modified and issues bus command 2'b10 (claim, which invalidates other copies).
- R6: A snooped read moves an Exclusive or Shared line to Shared, with `shared_hit`=1 and no bus command. On an Invalid line it changes nothing and `shared_hit`=0.
- R7: A snooped read or write of a Modified line sets `supply_data`=1 and issues bus command 2'b11 (flush). The line's next state is Shared after a snooped read and Invalid after a snooped write.
- R8: A snooped write moves a Shared or Exclusive line to Invalid with no bus command, `supply_data`=0 and `shared_hit`=0.
- R9: When `snp_valid` and `lcl_valid` are both 1 in the same cycle, only the snoop is served (`rsp_snoop`=1). The local request leaves its line unchanged.
- R10: Outputs are registered. The response to an event presented in cycle T is visible after clock edge T. In a cycle with no event, `rsp_valid`=0 on the next cycle.
- R11: An event changes only the addressed line; every other line keeps its state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lcl_valid | input | 1 | Local processor request present |
| lcl_write | input | 1 | 1 = local write, 0 = local read |
| lcl_addr | input | ADDR_W | Line address of the local request |
| lcl_shared | input | 1 | Bus shared response seen on a local read miss |
| snp_valid | input | 1 | Snooped bus event present |
| snp_write | input | 1 | 1 = remote write/claim, 0 = remote read |
| snp_addr | input | ADDR_W | Line address of the snooped event |
| rsp_valid | output | 1 | A response is presented this cycle |
| rsp_snoop | output | 1 | The response belongs to a snooped event |
| rsp_prev | output | 2 | Line state before the event |
| rsp_next | output | 2 | Line state after the event |
| bus_cmd | output | 2 | 00 none, 01 fetch, 10 claim, 11 flush |
| supply_data | output | 1 | This cache must drive the line's data onto the bus |
| shared_hit | output | 1 | A snooped read found a valid copy here |

## Verification
The bench drives every (event, state) pair by first building each source state through earlier events. Local reads are applied to Invalid and to valid lines, and read misses are tried with the shared response both set and clear; these patterns separate the fetch path from silent hits and separate the Exclusive outcome from the Shared one. Snooped reads and writes are aimed at Modified, Exclusive, Shared and Invalid lines, which shows that only a dirty line triggers the flush and data supply. A snoop and a local request in the same cycle, followed by a later read of the local address, confirm that the snoop wins. Reading back neighbouring lines shows that no other line changed.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10,
    LS_MOD = 2'b11
  } line_state_t;

  typedef enum logic [1:0] {
    BC_NONE  = 2'b00,
    BC_FETCH = 2'b01,
    BC_CLAIM = 2'b10,
    BC_FLUSH = 2'b11
  } bus_cmd_t;

  typedef struct packed {
    line_state_t nxt;
    bus_cmd_t    cmd;
    logic        supply;
    logic        shared_hit;
  } xition_t;

endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  output line_state_t       rd_state,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  line_state_t       wr_state
);
  localparam int DEPTH = 1 << ADDR_W;

  line_state_t lines [DEPTH];

  // one register per line so that reset clears the whole array at once
  for (genvar g = 0; g < DEPTH; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        lines[g] <= LS_INV;
      end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
        lines[g] <= wr_state;
      end
    end
  end

  assign rd_state = lines[rd_addr];

endmodule

// File: rtl/mesi_transition.sv
module mesi_transition
  import mesi_pkg::*;
(
  input  line_state_t cur,
  input  logic        is_snoop,
  input  logic        is_write,
  input  logic        shared_in,
  output xition_t     res
);
  always_comb begin
    res.nxt        = cur;
    res.cmd        = BC_NONE;
    res.supply     = 1'b0;
    res.shared_hit = 1'b0;
    if (!is_snoop) begin
      if (!is_write) begin
        if (cur == LS_INV) begin
          res.cmd = BC_FETCH;
          res.nxt = shared_in ? LS_SHR : LS_EXC;
        end
      end else begin
        res.nxt = LS_MOD;
        if (cur == LS_INV || cur == LS_SHR) begin
          res.cmd = BC_CLAIM;
        end
      end
    end else begin
      if (cur == LS_MOD) begin
        res.cmd    = BC_FLUSH;
        res.supply = 1'b1;
      end
      if (!is_write) begin
        res.shared_hit = (cur != LS_INV);
        if (cur != LS_INV) begin
          res.nxt = LS_SHR;
        end
      end else begin
        res.nxt = LS_INV;
      end
    end
  end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lcl_valid,
  input  logic              lcl_write,
  input  logic [ADDR_W-1:0] lcl_addr,
  input  logic              lcl_shared,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              rsp_valid,
  output logic              rsp_snoop,
  output logic [1:0]        rsp_prev,
  output logic [1:0]        rsp_next,
  output logic [1:0]        bus_cmd,
  output logic              supply_data,
  output logic              shared_hit
);
  logic              act;
  logic              pick_snp;
  logic [ADDR_W-1:0] sel_addr;
  logic              sel_write;
  line_state_t       cur_state;
  xition_t           xres;

  // the bus carries one action per cycle: a snoop wins over a local request
  assign pick_snp  = snp_valid;
  assign act       = snp_valid | lcl_valid;
  assign sel_addr  = pick_snp ? snp_addr  : lcl_addr;
  assign sel_write = pick_snp ? snp_write : lcl_write;

  mesi_state_array #(.ADDR_W(ADDR_W)) u_array (
    .clk      (clk),
    .rst      (rst),
    .rd_addr  (sel_addr),
    .rd_state (cur_state),
    .wr_en    (act),
    .wr_addr  (sel_addr),
    .wr_state (xres.nxt)
  );

  mesi_transition u_xition (
    .cur       (cur_state),
    .is_snoop  (pick_snp),
    .is_write  (sel_write),
    .shared_in (lcl_shared),
    .res       (xres)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_snoop   <= 1'b0;
      rsp_prev    <= 2'b00;
      rsp_next    <= 2'b00;
      bus_cmd     <= 2'b00;
      supply_data <= 1'b0;
      shared_hit  <= 1'b0;
    end else begin
      rsp_valid   <= act;
      rsp_snoop   <= act & pick_snp;
      rsp_prev    <= act ? cur_state : 2'b00;
      rsp_next    <= act ? xres.nxt : 2'b00;
      bus_cmd     <= act ? xres.cmd : BC_NONE;
      supply_data <= act & xres.supply;
      shared_hit  <= act & xres.shared_hit;
    end
  end

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       lcl_valid,
  input logic       snp_valid,
  input logic       snp_write,
  input logic       rsp_valid,
  input logic       rsp_snoop,
  input logic [1:0] rsp_prev,
  input logic [1:0] rsp_next,
  input logic [1:0] bus_cmd,
  input logic       supply_data,
  input logic       shared_hit
);
  // R10: no event means no response on the next cycle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!lcl_valid && !snp_valid) |=> !rsp_valid);

  // R9: a snoop is always the event that gets served
  a_r9_snoop_wins: assert property (@(posedge clk) disable iff (rst)
    snp_valid |=> (rsp_valid && rsp_snoop));

  // R7: data is supplied only together with a flush of a dirty line
  a_r7_flush_first: assert property (@(posedge clk) disable iff (rst)
    supply_data |-> (bus_cmd == 2'b11 && rsp_prev == 2'b11 && rsp_snoop));

  // R7: a snooped write to a dirty line leaves it Invalid
  a_r7_write_drops: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_write) |=> (rsp_next == 2'b00 && !shared_hit));

  // R5: a claim always ends in Modified from a local write
  a_r5_claim_owns: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && bus_cmd == 2'b10) |-> (!rsp_snoop && rsp_next == 2'b11));

  // R2: a fetch only happens on a local miss
  a_r2_fetch_miss: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && bus_cmd == 2'b01) |-> (!rsp_snoop && rsp_prev == 2'b00));

  // R8: a snoop never leaves this cache with an owning copy
  a_r8_snoop_no_own: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_snoop) |-> (rsp_next == 2'b00 || rsp_next == 2'b01));

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .lcl_valid   (lcl_valid),
  .snp_valid   (snp_valid),
  .snp_write   (snp_write),
  .rsp_valid   (rsp_valid),
  .rsp_snoop   (rsp_snoop),
  .rsp_prev    (rsp_prev),
  .rsp_next    (rsp_next),
  .bus_cmd     (bus_cmd),
  .supply_data (supply_data),
  .shared_hit  (shared_hit)
);

// File: tb/mesi_line_ctrl_bench.sv
module mesi_line_ctrl_bench;
  localparam int AW = 4;
  localparam logic [1:0] I = 2'b00, S = 2'b01, E = 2'b10, M = 2'b11;
  localparam logic [1:0] C_NONE = 2'b00, C_FETCH = 2'b01, C_CLAIM = 2'b10, C_FLUSH = 2'b11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lcl_valid = 1'b0, lcl_write = 1'b0, lcl_shared = 1'b0;
  logic [AW-1:0] lcl_addr = '0;
  logic          snp_valid = 1'b0, snp_write = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          rsp_valid, rsp_snoop, supply_data, shared_hit;
  logic [1:0]    rsp_prev, rsp_next, bus_cmd;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  mesi_line_ctrl #(.ADDR_W(AW)) u_mesi_line_ctrl (
    .clk(clk), .rst(rst),
    .lcl_valid(lcl_valid), .lcl_write(lcl_write), .lcl_addr(lcl_addr), .lcl_shared(lcl_shared),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
    .rsp_valid(rsp_valid), .rsp_snoop(rsp_snoop), .rsp_prev(rsp_prev), .rsp_next(rsp_next),
    .bus_cmd(bus_cmd), .supply_data(supply_data), .shared_hit(shared_hit)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive on the falling edge, sample 1 ns after the next rising edge
  task automatic step(input logic lv, input logic lw, input logic [AW-1:0] la, input logic sh,
                      input logic sv, input logic sw, input logic [AW-1:0] sa);
    @(negedge clk);
    lcl_valid = lv; lcl_write = lw; lcl_addr = la; lcl_shared = sh;
    snp_valid = sv; snp_write = sw; snp_addr = sa;
    @(posedge clk);
    #1;
    lcl_valid = 1'b0; snp_valid = 1'b0; lcl_shared = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic snp, input logic [1:0] pv,
                            input logic [1:0] nx, input logic [1:0] cmd,
                            input logic sup, input logic shh);
    check({tag, " valid"},  rsp_valid, 1);
    check({tag, " snoop"},  rsp_snoop, snp);
    check({tag, " prev"},   rsp_prev, pv);
    check({tag, " next"},   rsp_next, nx);
    check({tag, " cmd"},    bus_cmd, cmd);
    check({tag, " supply"}, supply_data, sup);
    check({tag, " shared"}, shared_hit, shh);
  endtask

  task automatic t_reset();
    check("R1 rsp_valid after reset", rsp_valid, 0);
    check("R1 bus_cmd after reset", bus_cmd, 0);
    check("R1 supply after reset", supply_data, 0);
    step(1, 0, 4'd3, 0, 0, 0, 0);
    expect_rsp("R1/R2 miss no-share", 0, I, E, C_FETCH, 0, 0);
  endtask

  task automatic t_read_miss_shared();
    step(1, 0, 4'd5, 1, 0, 0, 0);
    expect_rsp("R2 miss shared", 0, I, S, C_FETCH, 0, 0);
  endtask

  task automatic t_read_hit();
    step(1, 0, 4'd3, 1, 0, 0, 0);
    expect_rsp("R3 hit E", 0, E, E, C_NONE, 0, 0);
    step(1, 0, 4'd5, 0, 0, 0, 0);
    expect_rsp("R3 hit S", 0, S, S, C_NONE, 0, 0);
  endtask

  task automatic t_write_silent();
    step(1, 1, 4'd3, 0, 0, 0, 0);
    expect_rsp("R4 write E", 0, E, M, C_NONE, 0, 0);
    step(1, 1, 4'd3, 0, 0, 0, 0);
    expect_rsp("R4 write M", 0, M, M, C_NONE, 0, 0);
    step(1, 0, 4'd3, 0, 0, 0, 0);
    expect_rsp("R3 hit M", 0, M, M, C_NONE, 0, 0);
  endtask

  task automatic t_write_claim();
    step(1, 1, 4'd5, 0, 0, 0, 0);
    expect_rsp("R5 write S", 0, S, M, C_CLAIM, 0, 0);
    step(1, 1, 4'd7, 0, 0, 0, 0);
    expect_rsp("R5 write I", 0, I, M, C_CLAIM, 0, 0);
  endtask

  task automatic t_snoop_dirty();
    step(0, 0, 0, 0, 1, 0, 4'd3);
    expect_rsp("R7 snoop read M", 1, M, S, C_FLUSH, 1, 1);
    step(0, 0, 0, 0, 1, 1, 4'd5);
    expect_rsp("R7 snoop write M", 1, M, I, C_FLUSH, 1, 0);
  endtask

  task automatic t_snoop_read_clean();
    step(1, 0, 4'd8, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 4'd8);
    expect_rsp("R6 snoop read E", 1, E, S, C_NONE, 0, 1);
    step(0, 0, 0, 0, 1, 0, 4'd8);
    expect_rsp("R6 snoop read S", 1, S, S, C_NONE, 0, 1);
    step(0, 0, 0, 0, 1, 0, 4'd9);
    expect_rsp("R6 snoop read I", 1, I, I, C_NONE, 0, 0);
  endtask

  task automatic t_snoop_write_clean();
    step(0, 0, 0, 0, 1, 1, 4'd8);
    expect_rsp("R8 snoop write S", 1, S, I, C_NONE, 0, 0);
    step(1, 0, 4'd10, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1, 4'd10);
    expect_rsp("R8 snoop write E", 1, E, I, C_NONE, 0, 0);
  endtask

  task automatic t_collision();
    step(1, 1, 4'd12, 0, 1, 0, 4'd9);
    expect_rsp("R9 collision snoop served", 1, I, I, C_NONE, 0, 0);
    step(1, 0, 4'd12, 0, 0, 0, 0);
    expect_rsp("R9 dropped local untouched", 0, I, E, C_FETCH, 0, 0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    @(posedge clk);
    #1;
    check("R10 idle rsp_valid", rsp_valid, 0);
    check("R10 idle supply", supply_data, 0);
  endtask

  task automatic t_independent();
    step(1, 0, 4'd3, 0, 0, 0, 0);
    expect_rsp("R11 line 3 kept S", 0, S, S, C_NONE, 0, 0);
    step(1, 0, 4'd7, 0, 0, 0, 0);
    expect_rsp("R11 line 7 kept M", 0, M, M, C_NONE, 0, 0);
    step(1, 0, 4'd5, 1, 0, 0, 0);
    expect_rsp("R11 line 5 kept I", 0, I, S, C_FETCH, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_read_miss_shared();
    t_read_hit();
    t_write_silent();
    t_write_claim();
    t_snoop_dirty();
    t_snoop_read_clean();
    t_snoop_write_clean();
    t_collision();
    t_idle();
    t_independent();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule